// File: doc/BRIEF.md
# Pipeline Hazard Stall and Zap Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the source registers named by the instruction in decode and at the instruction in execute. It then tells the datapath whether to freeze the front end, squash the decode slot, or redirect fetch.

Two hazards are handled. The first is a load-use dependence. The value a load fetches appears only after the memory stage, so an instruction that reads that register right behind the load cannot take it from the forwarding paths in time. The decode instruction and the fetch PC are held for one cycle, and a bubble goes into execute. The second is a branch or jump resolved as taken in execute. The two younger instructions are on the wrong path. Fetch is redirected to the target, the fetch/decode register is cleared to a nop, and a bubble replaces the decode instruction.

The block keeps one bit of state: whether the execute stage holds a bubble that this block inserted. Execute-stage fields are ignored for one cycle after a bubble, so stale destination fields left in a bubble slot cannot raise a false stall.

Top module: `hz_stall_ctrl`

## Requirements
- R1: On the first cycle after reset is released, the execute stage counts as empty, so a load-use match raises no stall.
- R2: When execute holds a writing load and a used decode source register (non-zero) equals its destination, the block raises pc_hold, ifid_hold and idex_bubble. In the same cycle it leaves ifid_flush and pc_redirect low. Either source slot can make the match.
- R3: A source register number of 0 never causes a stall, because register 0 always reads as zero.
- R4: A source slot whose used flag is low never causes a stall.
- R5: No stall when the execute instruction does not write a register (ex_wr_en low) or is not a load (ex_is_load low).
- R6: A taken branch in execute raises ifid_flush, idex_bubble and pc_redirect, with pc_hold and ifid_hold low.
- R7: When a taken branch and a load-use match occur in the same cycle, the branch wins: the outputs are exactly those of R6.
- R8: In the cycle after idex_bubble was high, the execute-stage inputs are ignored and no stall is raised.
- R9: With no branch and no load-use match, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_idx | input | NUM_SRC*REG_AW | Decode-stage source register numbers, slot 0 in the low bits |
| id_src_used | input | NUM_SRC | Per-slot flag: the decode instruction reads this source |
| ex_dst_idx | input | REG_AW | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_br_taken | input | 1 | Branch or jump in execute resolved as taken |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register to a nop |
| idex_bubble | output | 1 | Load a nop into the decode/execute register |
| pc_redirect | output | 1 | Load the PC with the resolved branch target |

## Verification
The hardest situation to reach is the one covered by R8. Execute still presents a matching load while the block's own record says that slot is a bubble. A well-behaved datapath would never produce this. The stimulus creates it on purpose by repeating the exact load-use inputs in the cycle right after a stall, and again right after a branch zap. The bench also arranges a branch and a load-use match in the same cycle, and places the match in each source slot in turn.

// File: rtl/hz_pkg.sv
// Package: shared types for the hazard controller.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package hz_pkg;

    // Action chosen for the current cycle, highest priority first: ZAP, STALL, RUN.
    typedef enum logic [1:0] {
        HZ_RUN   = 2'd0,
        HZ_STALL = 2'd1,
        HZ_ZAP   = 2'd2
    } hz_act_e;

    // Control bundle driven toward the pipeline registers and the PC.
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_flush;
        logic idex_bubble;
        logic pc_redirect;
    } hz_ctrl_t;

endpackage

// File: rtl/hz_src_match.sv
// Module: hz_src_match
// Compares every decode source slot against the execute destination.
// A slot hits only if it is used, its register is non-zero and the
// destination is live. Assumes dst_live already folds in write/load/empty.
module hz_src_match #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_AW-1:0] src_idx,
    input  logic [NUM_SRC-1:0]        src_used,
    input  logic [REG_AW-1:0]         dst_idx,
    input  logic                      dst_live,
    output logic                      hit
);

    logic [NUM_SRC-1:0] slot_hit;

    // One comparator per source slot.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic [REG_AW-1:0] idx;
        assign idx         = src_idx[g*REG_AW +: REG_AW];
        assign slot_hit[g] = src_used[g] && (idx != '0) && (idx == dst_idx) && dst_live;
    end

    // Any slot hit is a load-use dependence.
    always_comb hit = |slot_hit;

endmodule

// File: rtl/hz_ex_track.sv
// Module: hz_ex_track
// Remembers whether the execute stage holds a bubble this block inserted.
// After reset the pipeline is empty, so the flag starts set.
module hz_ex_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bubble_in,
    output logic ex_empty
);

    // Capture this cycle's bubble decision for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ex_empty <= 1'b1;
        else        ex_empty <= bubble_in;
    end

endmodule

// File: rtl/hz_decide.sv
// Module: hz_decide
// Picks the action for the cycle and expands it into control lines.
// Branch zap wins over a load-use stall.
module hz_decide
    import hz_pkg::*;
(
    input  logic     br_taken,
    input  logic     load_use,
    output hz_ctrl_t ctrl
);

    hz_act_e act;

    // Priority selection of the action.
    always_comb begin
        if (br_taken)      act = HZ_ZAP;
        else if (load_use) act = HZ_STALL;
        else               act = HZ_RUN;
    end

    // Expand the action into individual controls.
    always_comb begin
        ctrl = '0;
        unique case (act)
            HZ_ZAP: begin
                ctrl.ifid_flush  = 1'b1;
                ctrl.idex_bubble = 1'b1;
                ctrl.pc_redirect = 1'b1;
            end
            HZ_STALL: begin
                ctrl.pc_hold     = 1'b1;
                ctrl.ifid_hold   = 1'b1;
                ctrl.idex_bubble = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/hz_stall_ctrl.sv
// Module: hz_stall_ctrl (top)
// Hazard controller for a five-stage in-order pipeline: load-use stall and
// taken-branch zap. Assumes the branch is resolved in execute and that
// forwarding covers all non-load producers.
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*REG_AW-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]        id_src_used,
    input  logic [REG_AW-1:0]         ex_dst_idx,
    input  logic                      ex_wr_en,
    input  logic                      ex_is_load,
    input  logic                      ex_br_taken,
    output logic                      pc_hold,
    output logic                      ifid_hold,
    output logic                      ifid_flush,
    output logic                      idex_bubble,
    output logic                      pc_redirect
);

    logic     ex_empty;
    logic     dst_live;
    logic     load_use;
    hz_ctrl_t ctrl;

    // Execute produces a late value only for a real, writing load.
    always_comb dst_live = ex_wr_en && ex_is_load && !ex_empty;

    hz_src_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_match (
        .src_idx  (id_src_idx),
        .src_used (id_src_used),
        .dst_idx  (ex_dst_idx),
        .dst_live (dst_live),
        .hit      (load_use)
    );

    hz_decide u_decide (
        .br_taken (ex_br_taken),
        .load_use (load_use),
        .ctrl     (ctrl)
    );

    hz_ex_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bubble_in (ctrl.idex_bubble),
        .ex_empty  (ex_empty)
    );

    // Drive the output pins from the control bundle.
    always_comb begin
        pc_hold     = ctrl.pc_hold;
        ifid_hold   = ctrl.ifid_hold;
        ifid_flush  = ctrl.ifid_flush;
        idex_bubble = ctrl.idex_bubble;
        pc_redirect = ctrl.pc_redirect;
    end

endmodule

// File: rtl/hz_stall_ctrl_chk.sv
// Module: hz_stall_ctrl_chk
// Property checker bound into hz_stall_ctrl; observes ports only.
module hz_stall_ctrl_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC*REG_AW-1:0] id_src_idx,
    input logic                      ex_br_taken,
    input logic                      pc_hold,
    input logic                      ifid_hold,
    input logic                      ifid_flush,
    input logic                      idex_bubble,
    input logic                      pc_redirect
);

    p_hold_implies_bubble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_bubble && !pc_redirect));

    p_zero_src_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_src_idx == '0) |-> !pc_hold);

    p_branch_zap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_br_taken |-> (ifid_flush && pc_redirect && idex_bubble && !pc_hold));

    p_flush_excl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_flush && ifid_hold));

    p_after_bubble_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !pc_hold);

endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_src_idx  (id_src_idx),
    .ex_br_taken (ex_br_taken),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_flush  (ifid_flush),
    .idex_bubble (idex_bubble),
    .pc_redirect (pc_redirect)
);

// File: tb/hz_stall_ctrl_bench.sv
// Scoreboard bench for hz_stall_ctrl: the driver pushes expected controls,
// the monitor pops and compares them mid-cycle.
module hz_stall_ctrl_bench;

    localparam int AW = 5;
    localparam int NS = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS*AW-1:0]  id_src_idx = '0;
    logic [NS-1:0]     id_src_used = '0;
    logic [AW-1:0]     ex_dst_idx = '0;
    logic              ex_wr_en = 1'b0;
    logic              ex_is_load = 1'b0;
    logic              ex_br_taken = 1'b0;
    logic pc_hold, ifid_hold, ifid_flush, idex_bubble, pc_redirect;

    int n_run  = 0;
    int n_fail = 0;
    logic m_prev_bubble = 1'b1;
    bit done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    hz_stall_ctrl #(.REG_AW(AW), .NUM_SRC(NS)) u_hz_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .id_src_idx(id_src_idx), .id_src_used(id_src_used),
        .ex_dst_idx(ex_dst_idx), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
        .ex_br_taken(ex_br_taken), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .ifid_flush(ifid_flush), .idex_bubble(idex_bubble), .pc_redirect(pc_redirect)
    );

    // Driver: apply inputs now (just after a falling edge), push expectation,
    // then wait for the next falling edge. Bits: {pc_hold, ifid_hold, flush, bubble, redirect}.
    task automatic step(input string tag, input logic [4:0] s0, input logic [4:0] s1,
                        input logic [1:0] used, input logic [4:0] dst,
                        input logic wen, input logic ld, input logic br);
        logic hit;
        logic [4:0] e;
        id_src_idx  = {s1, s0};
        id_src_used = used;
        ex_dst_idx  = dst;
        ex_wr_en    = wen;
        ex_is_load  = ld;
        ex_br_taken = br;
        hit = (used[0] && s0 != 0 && s0 == dst) || (used[1] && s1 != 0 && s1 == dst);
        if (br)                                      e = 5'b00111;
        else if (!m_prev_bubble && wen && ld && hit) e = 5'b11010;
        else                                         e = 5'b00000;
        m_prev_bubble = e[1];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare outputs halfway between falling and rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                logic [4:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {pc_hold, ifid_hold, ifid_flush, idex_bubble, pc_redirect};
                n_run++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(8 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 first cycle after reset",  5'd5, 5'd0, 2'b01, 5'd5, 1, 1, 0);
        step("R9 idle",                      5'd1, 5'd2, 2'b11, 5'd3, 0, 0, 0);
        step("R2 match slot 0",              5'd5, 5'd2, 2'b11, 5'd5, 1, 1, 0);
        step("R8 repeat after stall",        5'd5, 5'd2, 2'b11, 5'd5, 1, 1, 0);
        step("R2 match slot 1",              5'd3, 5'd7, 2'b11, 5'd7, 1, 1, 0);
        step("R9 idle after stall",          5'd3, 5'd4, 2'b11, 5'd9, 1, 0, 0);
        step("R3 register zero",             5'd0, 5'd0, 2'b11, 5'd0, 1, 1, 0);
        step("R4 unused slot",               5'd9, 5'd1, 2'b10, 5'd9, 1, 1, 0);
        step("R5 no write",                  5'd9, 5'd1, 2'b11, 5'd9, 0, 1, 0);
        step("R5 not a load",                5'd9, 5'd1, 2'b11, 5'd9, 1, 0, 0);
        step("R6 taken branch",              5'd2, 5'd3, 2'b11, 5'd8, 1, 0, 1);
        step("R9 idle after zap",            5'd2, 5'd3, 2'b11, 5'd8, 0, 0, 0);
        step("R7 branch beats load-use",     5'd6, 5'd1, 2'b11, 5'd6, 1, 1, 1);
        step("R8 repeat after zap",          5'd6, 5'd1, 2'b11, 5'd6, 1, 1, 0);
        step("R2 both slots match",          5'd4, 5'd4, 2'b11, 5'd4, 1, 1, 0);
        step("R3 zero in slot 1 only",       5'd8, 5'd0, 2'b10, 5'd0, 1, 1, 0);
        step("R6 branch with idle front",    5'd0, 5'd0, 2'b00, 5'd0, 0, 0, 1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule